// File: doc/BRIEF.md
# Push-Button SDRAM Test Front End

This block lets a person exercise an SDRAM controller's host port from a development board. The inputs are one push button (already debounced), a 4-bit DIP switch and a reset. The block classifies button activity as a single click or a double click. A single click issues a write and a double click issues a read. The switch value is repeated as often as needed to fill the address and data buses. The read result is latched and shown on 8 LEDs, which alternate between its bytes.

The block drives the controller's request side: two addresses, write data and the two enables. It watches the controller's `busy`, `rd_ready` and `rd_data` signals. The address that both reads and writes use is fixed at reset from the switch. Each request follows a simple handshake. The enable stays high until the controller reports busy. After that, no new request is issued until busy falls again.

The click window and the LED byte period are parameters. The defaults are 300 ms and 0.5 s at 100 MHz, and a bench can shorten both.

Top module: `sdram_btn_tester`

## Requirements
- R1: While `rst` is high and in the cycle after, `wr_enable`, `rd_enable` and `led` are all zero. `wr_addr` and `rd_addr` take the switch value repeated, so that bit i equals `sw[i mod 4]`.
- R2: After reset, `wr_addr` and `rd_addr` do not change when the switch changes.
- R3: A press and release with no new press during the next CLICK_WINDOW cycles issues one write. `wr_data` is the switch value at the start of the write, repeated over 16 bits (switch 5 gives 0x5555). `wr_data` stays steady while `wr_enable` is high.
- R4: A press, release and second press inside the window issues one read and no write.
- R5: The enables are never high together. A raised enable stays high until `busy` is sampled high, then drops on the next clock.
- R6: A request starts only while `busy` is low and the block is idle. Clicks completed while a request is outstanding are discarded, not queued.
- R7: `rd_data` is captured on the clock edge where `rd_ready` is high. The LEDs show only bytes of the last captured word.
- R8: The LEDs show the low byte for TOGGLE_COUNT cycles, then the high byte for TOGGLE_COUNT cycles, and repeat.
- R9: The release of a double click's second press issues no extra request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz system clock |
| rst | input | 1 | Synchronous active-high reset |
| btn | input | 1 | Debounced push button, high while pressed |
| sw | input | 4 | DIP switch value |
| busy | input | 1 | Controller is processing a request |
| rd_ready | input | 1 | Controller read data is valid |
| rd_data | input | 16 | Controller read data |
| wr_addr | output | 24 | Write address {bank,row,column} |
| wr_data | output | 16 | Write data |
| wr_enable | output | 1 | Write request |
| rd_addr | output | 24 | Read address {bank,row,column} |
| rd_enable | output | 1 | Read request |
| led | output | 8 | Displayed byte of last read word |

## Verification
The assertions check several rules on every cycle: the two enables are never high together, an enable drops one cycle after busy is seen, no enable rises while a request is still outstanding, write data and the addresses stay steady, and read data is captured on `rd_ready`. Other behaviour shows only in the bench scenarios with a handshake responder. These include telling a single click from a double click, the repeated switch values, discarding clicks made during a long busy period, and the LEDs alternating between the two bytes of a read word.

// File: rtl/btn_tester_pkg.sv
package btn_tester_pkg;
  typedef enum logic [1:0] {
    CK_IDLE,
    CK_FIRST,
    CK_GAP,
    CK_SECOND
  } click_state_t;

  typedef enum logic [1:0] {
    RQ_IDLE,
    RQ_WRITE,
    RQ_READ,
    RQ_HOLD
  } req_state_t;
endpackage

// File: rtl/click_classifier.sv
module click_classifier
  import btn_tester_pkg::*;
#(
  parameter int WINDOW = 30_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic btn,
  output logic single_o,
  output logic double_o
);
  localparam int CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

  click_state_t st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= CK_IDLE;
      cnt      <= '0;
      single_o <= 1'b0;
      double_o <= 1'b0;
    end else begin
      single_o <= 1'b0;
      double_o <= 1'b0;
      case (st)
        CK_IDLE:   if (btn) st <= CK_FIRST;
        CK_FIRST:  if (!btn) begin
                     st  <= CK_GAP;
                     cnt <= '0;
                   end
        CK_GAP:    if (btn) begin
                     double_o <= 1'b1;
                     st       <= CK_SECOND;
                   end else if (cnt == LAST) begin
                     single_o <= 1'b1;
                     st       <= CK_IDLE;
                   end else begin
                     cnt <= cnt + 1'b1;
                   end
        default:   if (!btn) st <= CK_IDLE;
      endcase
    end
  end

  // R9: one classification per click sequence, never both kinds
  a_r9_events_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(single_o && double_o));
  a_r9_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    (single_o || double_o) |=> !(single_o || double_o));
endmodule

// File: rtl/host_req_driver.sv
module host_req_driver
  import btn_tester_pkg::*;
#(
  parameter int SW_W   = 4,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              single_i,
  input  logic              double_i,
  input  logic [SW_W-1:0]   sw,
  input  logic              busy,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_enable,
  output logic              rd_enable
);
  logic [ADDR_W-1:0] addr_fill;
  logic [DATA_W-1:0] data_fill;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_addr_rep
    assign addr_fill[i] = sw[i % SW_W];
  end
  for (genvar j = 0; j < DATA_W; j++) begin : g_data_rep
    assign data_fill[j] = sw[j % SW_W];
  end

  req_state_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= RQ_IDLE;
      wr_enable <= 1'b0;
      rd_enable <= 1'b0;
      wr_data   <= '0;
      wr_addr   <= addr_fill;
      rd_addr   <= addr_fill;
    end else begin
      case (st)
        RQ_IDLE: if (!busy) begin
          if (single_i) begin
            wr_data   <= data_fill;
            wr_enable <= 1'b1;
            st        <= RQ_WRITE;
          end else if (double_i) begin
            rd_enable <= 1'b1;
            st        <= RQ_READ;
          end
        end
        RQ_WRITE, RQ_READ: if (busy) begin
          wr_enable <= 1'b0;
          rd_enable <= 1'b0;
          st        <= RQ_HOLD;
        end
        default: if (!busy) st <= RQ_IDLE;
      endcase
    end
  end

  a_r5_one_enable: assert property (@(posedge clk) disable iff (rst)
    !(wr_enable && rd_enable));
  a_r5_drop_on_busy: assert property (@(posedge clk) disable iff (rst)
    ((wr_enable || rd_enable) && busy) |=> (!wr_enable && !rd_enable));
  a_r6_quiet_while_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && !wr_enable && !rd_enable) |=> (!wr_enable && !rd_enable));
  a_r3_data_steady: assert property (@(posedge clk) disable iff (rst)
    (wr_enable && $past(wr_enable)) |-> $stable(wr_data));
  a_r2_addr_fixed: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($stable(wr_addr) && $stable(rd_addr)));
endmodule

// File: rtl/led_byte_mux.sv
module led_byte_mux #(
  parameter int DATA_W       = 16,
  parameter int LED_W        = 8,
  parameter int TOGGLE_COUNT = 50_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_ready,
  input  logic [DATA_W-1:0] rd_data,
  output logic [LED_W-1:0]  led
);
  localparam int NBYTES = DATA_W / LED_W;
  localparam int SW_BITS = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam int TW = $clog2(TOGGLE_COUNT + 1);
  localparam logic [TW-1:0] T_LAST = TW'(TOGGLE_COUNT - 1);
  localparam logic [SW_BITS-1:0] S_LAST = SW_BITS'(NBYTES - 1);

  logic [DATA_W-1:0]  disp_q;
  logic [TW-1:0]      tcnt;
  logic [SW_BITS-1:0] sel;
  logic [LED_W-1:0]   part [NBYTES];

  for (genvar b = 0; b < NBYTES; b++) begin : g_part
    assign part[b] = disp_q[b*LED_W +: LED_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_q <= '0;
      tcnt   <= '0;
      sel    <= '0;
      led    <= '0;
    end else begin
      if (rd_ready) disp_q <= rd_data;
      if (tcnt == T_LAST) begin
        tcnt <= '0;
        sel  <= (sel == S_LAST) ? '0 : sel + 1'b1;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
      led <= part[sel];
    end
  end

  a_r7_capture: assert property (@(posedge clk) disable iff (rst)
    rd_ready |=> (disp_q == $past(rd_data)));
  a_r7_hold_display: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rd_ready)) |-> $stable(disp_q));
endmodule

// File: rtl/sdram_btn_tester.sv
module sdram_btn_tester #(
  parameter int SW_W         = 4,
  parameter int ADDR_W       = 24,
  parameter int DATA_W       = 16,
  parameter int LED_W        = 8,
  parameter int CLICK_WINDOW = 30_000_000,
  parameter int TOGGLE_COUNT = 50_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              btn,
  input  logic [SW_W-1:0]   sw,
  input  logic              busy,
  input  logic              rd_ready,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_enable,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_enable,
  output logic [LED_W-1:0]  led
);
  logic single_evt, double_evt;

  click_classifier #(.WINDOW(CLICK_WINDOW)) u_click (
    .clk(clk), .rst(rst), .btn(btn),
    .single_o(single_evt), .double_o(double_evt)
  );

  host_req_driver #(.SW_W(SW_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk(clk), .rst(rst), .single_i(single_evt), .double_i(double_evt),
    .sw(sw), .busy(busy), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .wr_data(wr_data), .wr_enable(wr_enable), .rd_enable(rd_enable)
  );

  led_byte_mux #(.DATA_W(DATA_W), .LED_W(LED_W), .TOGGLE_COUNT(TOGGLE_COUNT)) u_led (
    .clk(clk), .rst(rst), .rd_ready(rd_ready), .rd_data(rd_data), .led(led)
  );
endmodule

// File: tb/sim_sdram_btn_tester.sv
module sim_sdram_btn_tester;
  localparam int WIN = 20;
  localparam int TOG = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn = 1'b0;
  logic [3:0] sw = 4'hA;
  logic busy = 1'b0;
  logic rd_ready = 1'b0;
  logic [15:0] rd_data = '0;
  logic [23:0] wr_addr, rd_addr;
  logic [15:0] wr_data;
  logic wr_enable, rd_enable;
  logic [7:0] led;

  int errors = 0;
  int checks = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  int hold_cycles = 4;
  logic [15:0] last_wdata = '0;
  logic [15:0] rd_value = 16'hC3A5;

  always #10 clk = ~clk;

  sdram_btn_tester #(.CLICK_WINDOW(WIN), .TOGGLE_COUNT(TOG)) u0 (
    .clk(clk), .rst(rst), .btn(btn), .sw(sw), .busy(busy),
    .rd_ready(rd_ready), .rd_data(rd_data), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_enable(wr_enable), .rd_addr(rd_addr),
    .rd_enable(rd_enable), .led(led)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Handshake responder standing in for the memory controller
  initial begin
    forever begin
      @(negedge clk);
      if (wr_enable === 1'b1 || rd_enable === 1'b1) begin
        automatic bit is_rd = rd_enable;
        automatic logic [15:0] wd = wr_data;
        repeat (2) @(negedge clk);
        chk((is_rd ? rd_enable : wr_enable) === 1'b1, "R5", "enable held before busy",
            {31'd0, is_rd ? rd_enable : wr_enable}, 1);
        chk(!(wr_enable && rd_enable), "R5", "single enable", {wr_enable, rd_enable}, 0);
        busy = 1'b1;
        @(negedge clk);
        chk(!wr_enable && !rd_enable, "R5", "enable dropped after busy",
            {wr_enable, rd_enable}, 0);
        repeat (hold_cycles) @(negedge clk);
        if (is_rd) begin
          rd_data  = rd_value;
          rd_ready = 1'b1;
          @(negedge clk);
          rd_ready = 1'b0;
          rd_data  = 16'h0000;
        end
        busy = 1'b0;
        if (is_rd) rd_cnt++;
        else begin
          wr_cnt++;
          last_wdata = wd;
        end
      end
    end
  end

  task automatic press(input int n);
    btn = 1'b1;
    repeat (n) @(negedge clk);
    btn = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(wr_enable === 1'b0 && rd_enable === 1'b0, "R1", "enables in reset", {wr_enable, rd_enable}, 0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(wr_addr === 24'hAAAAAA, "R1", "wr_addr fill", wr_addr, 24'hAAAAAA);
    chk(rd_addr === 24'hAAAAAA, "R1", "rd_addr fill", rd_addr, 24'hAAAAAA);
    chk(led === 8'h00, "R1", "led after reset", led, 0);
    chk(wr_enable === 1'b0 && rd_enable === 1'b0, "R1", "enables after reset", {wr_enable, rd_enable}, 0);
  endtask

  task automatic t_addr_fixed;
    sw = 4'h3;
    repeat (5) @(negedge clk);
    chk(wr_addr === 24'hAAAAAA, "R2", "wr_addr after sw change", wr_addr, 24'hAAAAAA);
    chk(rd_addr === 24'hAAAAAA, "R2", "rd_addr after sw change", rd_addr, 24'hAAAAAA);
  endtask

  task automatic t_single_write;
    automatic int w0 = wr_cnt, r0 = rd_cnt;
    sw = 4'h5;
    press(3);
    repeat (WIN + 30) @(negedge clk);
    chk(wr_cnt == w0 + 1, "R3", "one write issued", wr_cnt, w0 + 1);
    chk(last_wdata === 16'h5555, "R3", "write data fill", last_wdata, 16'h5555);
    chk(rd_cnt == r0, "R3", "no read on single", rd_cnt, r0);
  endtask

  task automatic t_double_read;
    automatic int w0 = wr_cnt, r0 = rd_cnt;
    press(3);
    repeat (4) @(negedge clk);
    press(5);
    repeat (WIN + 40) @(negedge clk);
    chk(rd_cnt == r0 + 1, "R4", "one read issued", rd_cnt, r0 + 1);
    chk(wr_cnt == w0, "R9", "no write from second release", wr_cnt, w0);
  endtask

  task automatic t_led_alternate;
    automatic bit seen_lo = 0, seen_hi = 0, bad = 0;
    automatic logic [7:0] bad_v = 8'h00;
    for (int k = 0; k < 4 * TOG; k++) begin
      @(negedge clk);
      if (led === 8'hA5) seen_lo = 1;
      else if (led === 8'hC3) seen_hi = 1;
      else begin bad = 1; bad_v = led; end
    end
    chk(!bad, "R7", "led shows only captured bytes", bad_v, 8'hA5);
    chk(seen_lo, "R8", "low byte shown", seen_lo, 1);
    chk(seen_hi, "R8", "high byte shown", seen_hi, 1);
  endtask

  task automatic t_busy_discard;
    automatic int w0;
    hold_cycles = 80;
    sw = 4'h9;
    press(3);
    wait (busy === 1'b1);
    @(negedge clk);
    w0 = wr_cnt;
    press(3);
    repeat (WIN + 150) @(negedge clk);
    chk(wr_cnt == w0 + 1, "R6", "click during busy discarded", wr_cnt, w0 + 1);
    chk(rd_cnt == 1, "R6", "no stray read", rd_cnt, 1);
    hold_cycles = 4;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_addr_fixed();
    t_single_write();
    t_double_read();
    t_led_alternate();
    t_busy_discard();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule